// File: doc/BRIEF.md
# Vectored Exception Dispatch Unit

This unit is the exception front end of a simple 32-bit processor. It keeps no cause register. The kind of event is shown only by the handler entry address that the unit jumps to. In a given cycle it may see an arithmetic-overflow flag, an undefined-instruction flag, or both. The unit then picks a handler address from a small table of vectors. The table starts at `0xC0000000`, and its entries are `0x20` bytes apart. The unit also blocks writeback for the faulting instruction. It saves that instruction's address as the exception PC, which is the incremented PC minus four.

The unit has two states. `ST_RUN` means normal program execution. `ST_HANDLER` means a handler is running. Three transitions connect them:
- `TAKE_EXC` goes from `ST_RUN` to `ST_HANDLER` when any event is seen.
- `RETAKE_EXC` goes from `ST_HANDLER` back to `ST_HANDLER` when a new event arrives in handler code.
- `RETURN` goes from `ST_HANDLER` to `ST_RUN` when the return strobe is accepted.

Redirect, select and inhibit are combinational in the dispatch cycle. The processor's PC register loads the redirect address at the next clock edge.

Top module: `vec_dispatch_unit`

## Requirements
- R1: When the overflow flag is high and the undefined flag is low, `pc_sel_o` is 1 and `pc_redirect_o` is `0xC0000000` in that cycle. Overflow is event number 0.
- R2: When the undefined flag is high, `pc_redirect_o` is `0xC0000020` and `pc_sel_o` is 1 in that cycle. Undefined instruction is event number 1. Each vector is the base plus the event number times `0x20`.
- R3: After reset, the unit is in `ST_RUN`. `epc_o` is 0, and with idle inputs `pc_sel_o` and `wb_inhibit_o` are both 0.
- R4: At the clock edge that ends a dispatch cycle, `epc_o` takes the value `pc_plus4_i - 4`. At all other edges it keeps its value.
- R5: In `ST_HANDLER`, a return strobe with no event sets `pc_sel_o` to 1 and `pc_redirect_o` to `epc_o`, and the unit goes back to `ST_RUN`.
- R6: When both flags are high together, the undefined-instruction vector `0xC0000020` is chosen.
- R7: A return strobe in the same cycle as an event is ignored. The event vector is driven and the unit stays in `ST_HANDLER`, so a later strobe still returns.
- R8: `wb_inhibit_o` is 1 exactly in the cycles where an event is dispatched.
- R9: A return strobe in `ST_RUN` is ignored: `pc_sel_o` stays 0.
- R10: With no event and no accepted return, `pc_sel_o` and `wb_inhibit_o` are 0. `pc_redirect_o` has meaning only while `pc_sel_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pc_plus4_i | input | 32 | Incremented PC of the instruction in execution |
| ovf_i | input | 1 | Arithmetic overflow detected |
| undef_i | input | 1 | Undefined instruction detected |
| eret_i | input | 1 | Return-from-exception strobe |
| epc_o | output | 32 | Saved address of the faulting instruction |
| pc_redirect_o | output | 32 | Next-PC override value |
| pc_sel_o | output | 1 | Selects `pc_redirect_o` as the next PC |
| wb_inhibit_o | output | 1 | Blocks register and memory writes of the current instruction |

## Verification
Two functions can fall in the same cycle: a new exception dispatch and the return from a handler. They meet when an event flag and the return strobe are raised together while a handler is active. The bench does this with directed cases and with random cycles, some of which pair the two.

In such a cycle the event must win. The check looks at the vector on the redirect output and at the new `epc_o`. It then confirms that the unit is still in `ST_HANDLER` by sending a second strobe, which must redirect to the saved address.

// File: rtl/vxd_pkg.sv
package vxd_pkg;
    typedef enum logic {
        ST_RUN     = 1'b0,
        ST_HANDLER = 1'b1
    } vxd_state_e;

    localparam int unsigned EV_OVF   = 0;
    localparam int unsigned EV_UNDEF = 1;
    localparam int unsigned NUM_EV   = 2;
endpackage

// File: rtl/vxd_prio.sv
// Fixed priority: the highest-numbered active request wins.
module vxd_prio #(
    parameter int unsigned NUM_EV = 2,
    localparam int unsigned IDW   = (NUM_EV > 1) ? $clog2(NUM_EV) : 1
) (
    input  logic [NUM_EV-1:0] req_i,
    output logic              hit_o,
    output logic [IDW-1:0]    id_o
);
    always_comb begin
        hit_o = 1'b0;
        id_o  = '0;
        for (int i = 0; i < int'(NUM_EV); i++) begin
            if (req_i[i]) begin
                hit_o = 1'b1;
                id_o  = IDW'(i);
            end
        end
    end
endmodule

// File: rtl/vxd_vec_table.sv
module vxd_vec_table #(
    parameter int unsigned NUM_EV = 2,
    parameter int unsigned AW     = 32,
    parameter logic [AW-1:0] BASE = 32'hC000_0000,
    parameter int unsigned STRIDE = 32'h20,
    localparam int unsigned IDW   = (NUM_EV > 1) ? $clog2(NUM_EV) : 1
) (
    input  logic [IDW-1:0] id_i,
    output logic [AW-1:0]  addr_o
);
    logic [AW-1:0] tbl [NUM_EV];

    for (genvar gi = 0; gi < int'(NUM_EV); gi++) begin : g_entry
        assign tbl[gi] = BASE + AW'(STRIDE * gi);
    end

    always_comb begin
        addr_o = tbl[0];
        for (int i = 0; i < int'(NUM_EV); i++) begin
            if (id_i == IDW'(i)) addr_o = tbl[i];
        end
    end
endmodule

// File: rtl/vxd_epc_reg.sv
module vxd_epc_reg #(
    parameter int unsigned AW   = 32,
    parameter int unsigned ILEN = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_i,
    input  logic [AW-1:0] pc_plus4_i,
    output logic [AW-1:0] epc_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     epc_o <= '0;
        else if (cap_i) epc_o <= pc_plus4_i - AW'(ILEN);
    end

    AST_EPC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_i |=> $stable(epc_o)); // R4
endmodule

// File: rtl/vec_dispatch_unit.sv
module vec_dispatch_unit
    import vxd_pkg::*;
#(
    parameter int unsigned AW       = 32,
    parameter logic [AW-1:0] VBASE  = 32'hC000_0000,
    parameter int unsigned VSTRIDE  = 32'h20,
    parameter int unsigned ILEN     = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] pc_plus4_i,
    input  logic          ovf_i,
    input  logic          undef_i,
    input  logic          eret_i,
    output logic [AW-1:0] epc_o,
    output logic [AW-1:0] pc_redirect_o,
    output logic          pc_sel_o,
    output logic          wb_inhibit_o
);
    localparam int unsigned IDW = (NUM_EV > 1) ? $clog2(NUM_EV) : 1;

    vxd_state_e         state_q, state_d;
    logic [NUM_EV-1:0]  ev_req;
    logic               exc_hit;
    logic [IDW-1:0]     ev_id;
    logic [AW-1:0]      vec_addr;
    logic               ret_take;

    always_comb begin
        ev_req           = '0;
        ev_req[EV_OVF]   = ovf_i;
        ev_req[EV_UNDEF] = undef_i;
    end

    vxd_prio #(.NUM_EV(NUM_EV)) u_prio (
        .req_i (ev_req),
        .hit_o (exc_hit),
        .id_o  (ev_id)
    );

    vxd_vec_table #(
        .NUM_EV (NUM_EV),
        .AW     (AW),
        .BASE   (VBASE),
        .STRIDE (VSTRIDE)
    ) u_vec (
        .id_i   (ev_id),
        .addr_o (vec_addr)
    );

    vxd_epc_reg #(.AW(AW), .ILEN(ILEN)) u_epc (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap_i      (exc_hit),
        .pc_plus4_i (pc_plus4_i),
        .epc_o      (epc_o)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // Outputs and transitions
    always_comb begin
        state_d       = state_q;
        pc_sel_o      = 1'b0;
        pc_redirect_o = vec_addr;
        wb_inhibit_o  = 1'b0;
        ret_take      = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (exc_hit) begin            // TAKE_EXC
                    pc_sel_o     = 1'b1;
                    wb_inhibit_o = 1'b1;
                    state_d      = ST_HANDLER;
                end
            end
            ST_HANDLER: begin
                if (exc_hit) begin            // RETAKE_EXC, return ignored
                    pc_sel_o     = 1'b1;
                    wb_inhibit_o = 1'b1;
                end else if (eret_i) begin    // RETURN
                    pc_sel_o      = 1'b1;
                    pc_redirect_o = epc_o;
                    ret_take      = 1'b1;
                    state_d       = ST_RUN;
                end
            end
            default: state_d = ST_RUN;
        endcase
    end

    AST_EPC_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        wb_inhibit_o |=> epc_o == $past(pc_plus4_i) - AW'(ILEN)); // R4
    AST_UNDEF_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        undef_i |-> pc_sel_o && pc_redirect_o == VBASE + AW'(VSTRIDE)); // R6
    AST_OVF_VEC: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_i && !undef_i) |-> pc_sel_o && pc_redirect_o == VBASE); // R1
    AST_RETURN_EPC: assert property (@(posedge clk) disable iff (!rst_n)
        ret_take |-> pc_redirect_o == epc_o && !wb_inhibit_o); // R5
    AST_RET_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (eret_i && (ovf_i || undef_i)) |=> state_q == ST_HANDLER); // R7
    AST_INHIBIT_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        wb_inhibit_o |-> pc_sel_o); // R8
    AST_RUN_NO_RET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !ovf_i && !undef_i) |-> !pc_sel_o); // R9
endmodule

// File: tb/vec_dispatch_unit_tb.sv
`timescale 1ns/1ps
module vec_dispatch_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pc_plus4_i = '0;
    logic        ovf_i = 1'b0, undef_i = 1'b0, eret_i = 1'b0;
    logic [31:0] epc_o, pc_redirect_o;
    logic        pc_sel_o, wb_inhibit_o;

    int n_chk = 0, n_fail = 0;
    logic        m_hand = 1'b0;
    logic [31:0] m_epc  = '0;
    bit          done   = 1'b0;

    always #2 clk = ~clk;

    vec_dispatch_unit u_dut (
        .clk(clk), .rst_n(rst_n), .pc_plus4_i(pc_plus4_i),
        .ovf_i(ovf_i), .undef_i(undef_i), .eret_i(eret_i),
        .epc_o(epc_o), .pc_redirect_o(pc_redirect_o),
        .pc_sel_o(pc_sel_o), .wb_inhibit_o(wb_inhibit_o)
    );

    function automatic logic [31:0] vec_of(input logic ov, input logic ud);
        return ud ? 32'hC000_0020 : 32'hC000_0000;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic ov, input logic ud, input logic er, input logic [31:0] pc);
        logic exc, rt, esel;
        string tag;
        @(negedge clk);
        ovf_i = ov; undef_i = ud; eret_i = er; pc_plus4_i = pc;
        #1;
        exc  = ov | ud;
        rt   = !exc && er && m_hand;
        esel = exc | rt;
        if (ov && ud)      tag = "R6";
        else if (ud)       tag = "R2";
        else if (ov)       tag = "R1";
        else if (rt)       tag = "R5";
        else if (er)       tag = "R9";
        else               tag = "R10";
        if (er && exc) tag = {tag, "/R7"};
        check(tag, {31'd0, pc_sel_o}, {31'd0, esel});
        check("R8", {31'd0, wb_inhibit_o}, {31'd0, exc});
        if (esel) check(tag, pc_redirect_o, exc ? vec_of(ov, ud) : m_epc);
        @(posedge clk);
        if (exc) begin m_epc = pc - 32'd4; m_hand = 1'b1; end
        else if (rt) m_hand = 1'b0;
        #1;
        check("R4", epc_o, m_epc);
    endtask

    initial begin
        #(4 * 20000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        repeat (2) @(negedge clk);
        #1;
        check("R3", epc_o, 32'd0);
        check("R3", {30'd0, pc_sel_o, wb_inhibit_o}, 32'd0);
        rst_n = 1'b1;
        step(0, 0, 1, 32'h0000_1000);           // R9 return while running
        step(1, 0, 0, 32'h0000_2004);           // R1 overflow
        step(0, 0, 0, 32'h0000_3008);           // R10 idle in handler
        step(0, 0, 1, 32'h0000_4000);           // R5 return
        step(0, 1, 0, 32'h0040_0010);           // R2 undefined
        step(0, 0, 1, 32'h0000_0000);           // R5
        step(1, 1, 0, 32'h1234_5678);           // R6 both
        step(1, 0, 1, 32'h0000_8888);           // R7 return ignored
        step(0, 0, 1, 32'h0000_9999);           // R7 later return works
        step(0, 1, 1, 32'h0000_0004);           // R7 in run state
        step(0, 0, 1, 32'h0000_0000);
        void'($urandom(32'd4242));
        for (int i = 0; i < 400; i++) begin
            r = $urandom;
            step(r[2:0] == 3'd0, r[5:3] == 3'd0, r[7:6] != 2'd0,
                 $urandom & 32'hFFFF_FFFC);
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule